// File: doc/BRIEF.md
# Adaptive-Bandwidth Oscillator Disciplining Loop

This block steers an external voltage-controlled crystal oscillator so that its divided clock follows a reference rate. The reference is the frame-sync clock recovered from an incoming digital audio stream, delivered as one-cycle tick pulses. The local side delivers ticks derived from the oscillator master clock. Over a programmable window the block counts both kinds of tick and takes the signed difference. A proportional-integral filter turns that difference into a code word for the oscillator's control DAC. A one-cycle strobe marks each new code.

The loop changes its own bandwidth while it runs. It starts in an acquisition mode with large gains so that it pulls in quickly. After a run of quiet windows it moves to a tracking mode with small gains and a low corner. After a second quiet run it enters a hold mode. In hold mode the code is left alone for a programmable dwell, counted in windows. At the end of each dwell the code moves by a single LSB in the direction of the summed error. A large error in any locked mode drops the loop back to acquisition. A slip reported by the downstream data buffer is counted, and a slip during hold sends the loop back to tracking.

Top module: `vcxo_loop_ctrl`

## Requirements
- R1: After synchronous reset, the outputs are as follows: `dac_code` is mid-scale (2^(DAC_W-1)), `mode` is 0 (acquire), `locked` is 0, `dac_valid` is 0 and `slip_count` is 0.
- R2: A window lasts `win_len` clock cycles, with `win_len` at least 2. The window error is the number of `ref_tick` pulses in the window minus the number of `loc_tick` pulses. When `invert_err` is 1 the error is negated. A positive error raises the code and a negative error lowers it.
- R3: In acquire mode (0) and track mode (1), each window end updates the integrator by err·2^I_SH, clamped to [-MID, MID-1]. The code becomes MID + integrator + err·2^P_SH, clamped. The shifts are ACQ_*_SH in acquire mode and TRK_*_SH in track mode. `dac_valid` pulses for one cycle with each update.
- R4: `dac_code` stays within [0, 2^DAC_W-1] and saturates at the limits without wrapping.
- R5: Acquire mode moves to track mode after `lock_n` consecutive windows with |err| ≤ `lock_thr`. `locked` is 1 exactly while `mode` is 1 or 2. A window that is not quiet restarts the run.
- R6: Track mode moves to hold mode (2) after `lock_n` further consecutive quiet windows. Hold mode is entered only from track mode.
- R7: In hold mode the code changes only at the end of each dwell of `dwell_len` windows. It then changes by exactly +1, -1 or 0, following the sign of the error summed over that dwell, and `dac_valid` pulses.
- R8: In track or hold mode, a window with |err| > `unlock_thr` returns the loop to acquire mode with `locked` = 0.
- R9: Each `slip_in` pulse increments `slip_count`, which saturates at its maximum value. A slip during hold mode returns the loop to track mode on the next clock, unless the same window end also unlocks. A slip in the other modes does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference frame-sync edge |
| loc_tick | input | 1 | One-cycle pulse per divided local-oscillator edge |
| slip_in | input | 1 | One-cycle slip report from the downstream buffer |
| invert_err | input | 1 | Negates the window error |
| win_len | input | WIN_W | Window length in clock cycles (≥ 2) |
| dwell_len | input | DWELL_W | Hold dwell length in windows (≥ 1) |
| lock_thr | input | CNT_W | Quiet threshold on the absolute error |
| unlock_thr | input | CNT_W | Unlock threshold on the absolute error |
| lock_n | input | GOOD_W | Consecutive quiet windows needed to advance (≥ 1) |
| dac_code | output | DAC_W | Oscillator control DAC code |
| dac_valid | output | 1 | One-cycle strobe per code update |
| mode | output | 2 | 0 acquire, 1 track, 2 hold |
| locked | output | 1 | Lock indication |
| slip_count | output | SLIP_W | Saturating slip counter |

## Verification
The bench first applies equal tick rates, which give a zero error. This separates the lock and hold sequencing from any code movement. It then slows the reference slightly while the loop is in hold. The small negative error tells single-LSB dwell nudges apart from an ordinary filter update. A large positive error tells the unlock path and acquisition-gain saturation at the top code apart. The same error with inversion enabled must drive the code to zero instead. Slip pulses are applied in hold mode and in acquire mode, to show that only the hold mode reacts to them. On every cycle a behavioural model is compared against the code, strobe, mode, lock flag and slip count.

// File: rtl/vcxo_pkg.sv
package vcxo_pkg;

    typedef enum logic [1:0] {
        MODE_ACQ   = 2'd0,
        MODE_TRACK = 2'd1,
        MODE_HOLD  = 2'd2
    } loop_mode_e;

    function automatic longint clamp_l(input longint v, input longint lo, input longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic longint sign_step(input longint v);
        if (v > 0) return 1;
        if (v < 0) return -1;
        return 0;
    endfunction

endpackage

// File: rtl/vcxo_win_meter.sv
module vcxo_win_meter import vcxo_pkg::*; #(
    parameter int CNT_W = 10,
    parameter int WIN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_tick,
    input  logic                    loc_tick,
    input  logic                    invert_err,
    input  logic [WIN_W-1:0]        win_len,
    output logic                    win_done,
    output logic signed [CNT_W+1:0] err
);
    localparam int ERR_W = CNT_W + 2;

    logic [WIN_W-1:0]        wcnt;
    logic [CNT_W-1:0]        rcnt, lcnt;
    logic [CNT_W:0]          rtot, ltot;
    logic signed [ERR_W-1:0] diff;
    logic                    last;

    always_comb begin
        rtot = {1'b0, rcnt} + {{CNT_W{1'b0}}, ref_tick};
        ltot = {1'b0, lcnt} + {{CNT_W{1'b0}}, loc_tick};
        diff = $signed({1'b0, rtot}) - $signed({1'b0, ltot});
        last = (wcnt >= win_len - WIN_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt     <= '0;
            rcnt     <= '0;
            lcnt     <= '0;
            win_done <= 1'b0;
            err      <= '0;
        end else if (last) begin
            wcnt     <= '0;
            rcnt     <= '0;
            lcnt     <= '0;
            win_done <= 1'b1;
            err      <= invert_err ? -diff : diff;
        end else begin
            wcnt     <= wcnt + WIN_W'(1);
            rcnt     <= rtot[CNT_W-1:0];
            lcnt     <= ltot[CNT_W-1:0];
            win_done <= 1'b0;
        end
    end

    // R2: a window end is a single-cycle pulse
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        (win_done && win_len > WIN_W'(1)) |=> !win_done);

endmodule

// File: rtl/vcxo_loop_filter.sv
module vcxo_loop_filter import vcxo_pkg::*; #(
    parameter int DAC_W    = 10,
    parameter int CNT_W    = 10,
    parameter int DWELL_W  = 24,
    parameter int ACQ_P_SH = 3,
    parameter int ACQ_I_SH = 2,
    parameter int TRK_P_SH = 0,
    parameter int TRK_I_SH = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    win_done,
    input  logic signed [CNT_W+1:0] err,
    input  loop_mode_e              mode,
    input  logic [DWELL_W-1:0]      dwell_len,
    output logic [DAC_W-1:0]        dac_code,
    output logic                    dac_valid
);
    localparam longint MID      = longint'(1) << (DAC_W - 1);
    localparam longint CODE_MAX = (longint'(1) << DAC_W) - 1;
    localparam int     INT_W    = DAC_W + 1;
    localparam int     HACC_W   = CNT_W + 2 + DWELL_W;
    localparam int     DWE_W    = DWELL_W + 1;

    logic signed [INT_W-1:0]  integ;
    logic signed [HACC_W-1:0] hacc;
    logic [DWELL_W-1:0]       dwell_cnt;

    longint e, p_term, i_term, integ_n, code_n, hsum, nudged;
    logic   dwell_end;

    always_comb begin
        e       = longint'(err);
        p_term  = (mode == MODE_ACQ) ? (e <<< ACQ_P_SH) : (e <<< TRK_P_SH);
        i_term  = (mode == MODE_ACQ) ? (e <<< ACQ_I_SH) : (e <<< TRK_I_SH);
        integ_n = clamp_l(longint'(integ) + i_term, -MID, MID - 1);
        code_n  = clamp_l(MID + integ_n + p_term, 0, CODE_MAX);
        hsum    = longint'(hacc) + e;
        nudged  = clamp_l(longint'(dac_code) + sign_step(hsum), 0, CODE_MAX);
        dwell_end = ({1'b0, dwell_cnt} + DWE_W'(1)) >= {1'b0, dwell_len};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ     <= '0;
            hacc      <= '0;
            dwell_cnt <= '0;
            dac_code  <= DAC_W'(MID);
            dac_valid <= 1'b0;
        end else if (win_done) begin
            if (mode == MODE_HOLD) begin
                if (dwell_end) begin
                    dac_code  <= DAC_W'(nudged);
                    integ     <= INT_W'(nudged - MID);
                    hacc      <= '0;
                    dwell_cnt <= '0;
                    dac_valid <= 1'b1;
                end else begin
                    hacc      <= HACC_W'(hsum);
                    dwell_cnt <= dwell_cnt + DWELL_W'(1);
                    dac_valid <= 1'b0;
                end
            end else begin
                integ     <= INT_W'(integ_n);
                dac_code  <= DAC_W'(code_n);
                hacc      <= '0;
                dwell_cnt <= '0;
                dac_valid <= 1'b1;
            end
        end else begin
            dac_valid <= 1'b0;
            if (mode != MODE_HOLD) begin
                hacc      <= '0;
                dwell_cnt <= '0;
            end
        end
    end

    // R3: every code strobe follows a window end
    a_r3_strobe_after_window: assert property (@(posedge clk) disable iff (rst)
        dac_valid |-> $past(win_done));

    // R7: a hold-mode update moves the code by at most one LSB
    a_r7_hold_one_lsb: assert property (@(posedge clk) disable iff (rst)
        (dac_valid && $past(mode) == MODE_HOLD) |->
            ({1'b0, dac_code} == {1'b0, $past(dac_code)} ||
             {1'b0, dac_code} == {1'b0, $past(dac_code)} + INT_W'(1) ||
             {1'b0, dac_code} + INT_W'(1) == {1'b0, $past(dac_code)}));

endmodule

// File: rtl/vcxo_lock_fsm.sv
module vcxo_lock_fsm import vcxo_pkg::*; #(
    parameter int CNT_W  = 10,
    parameter int GOOD_W = 8,
    parameter int SLIP_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    win_done,
    input  logic signed [CNT_W+1:0] err,
    input  logic [CNT_W-1:0]        lock_thr,
    input  logic [CNT_W-1:0]        unlock_thr,
    input  logic [GOOD_W-1:0]       lock_n,
    input  logic                    slip_in,
    output loop_mode_e              mode,
    output logic                    locked,
    output logic [SLIP_W-1:0]       slip_count
);
    logic [CNT_W+1:0]        abs_err;
    logic signed [CNT_W+1:0] neg_err;
    logic                    quiet, loud, reach;
    logic [GOOD_W-1:0]       good;
    logic [GOOD_W:0]         good_nx;

    always_comb begin
        neg_err = -err;
        abs_err = err[CNT_W+1] ? neg_err : err;
        quiet   = abs_err <= {2'b00, lock_thr};
        loud    = abs_err >  {2'b00, unlock_thr};
        good_nx = {1'b0, good} + (GOOD_W+1)'(1);
        reach   = good_nx >= {1'b0, lock_n};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= MODE_ACQ;
            locked     <= 1'b0;
            good       <= '0;
            slip_count <= '0;
        end else begin
            if (slip_in && slip_count != '1)
                slip_count <= slip_count + SLIP_W'(1);
            if (win_done) begin
                case (mode)
                    MODE_ACQ: begin
                        if (quiet && reach) begin
                            mode   <= MODE_TRACK;
                            locked <= 1'b1;
                            good   <= '0;
                        end else if (quiet) begin
                            good <= good_nx[GOOD_W-1:0];
                        end else begin
                            good <= '0;
                        end
                    end
                    MODE_TRACK: begin
                        if (loud) begin
                            mode   <= MODE_ACQ;
                            locked <= 1'b0;
                            good   <= '0;
                        end else if (quiet && reach) begin
                            mode <= MODE_HOLD;
                            good <= '0;
                        end else if (quiet) begin
                            good <= good_nx[GOOD_W-1:0];
                        end else begin
                            good <= '0;
                        end
                    end
                    default: begin
                        if (loud) begin
                            mode   <= MODE_ACQ;
                            locked <= 1'b0;
                            good   <= '0;
                        end else if (slip_in) begin
                            mode <= MODE_TRACK;
                            good <= '0;
                        end
                    end
                endcase
            end else if (mode == MODE_HOLD && slip_in) begin
                mode <= MODE_TRACK;
                good <= '0;
            end
        end
    end

    // R5: lock flag agrees with the mode
    a_r5_locked_matches_mode: assert property (@(posedge clk) disable iff (rst)
        locked == (mode != MODE_ACQ));

    // R6: hold is only entered from track
    a_r6_hold_from_track: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD && $past(mode) != MODE_HOLD) |-> $past(mode) == MODE_TRACK);

    // R8: a loud window in a locked mode returns to acquire
    a_r8_unlock: assert property (@(posedge clk) disable iff (rst)
        (win_done && mode != MODE_ACQ && loud) |=> (mode == MODE_ACQ && !locked));

    // R9: each slip below saturation is counted
    a_r9_slip_count: assert property (@(posedge clk) disable iff (rst)
        (slip_in && slip_count != '1) |=> slip_count == $past(slip_count) + SLIP_W'(1));

endmodule

// File: rtl/vcxo_loop_ctrl.sv
module vcxo_loop_ctrl import vcxo_pkg::*; #(
    parameter int DAC_W    = 10,
    parameter int CNT_W    = 10,
    parameter int WIN_W    = 16,
    parameter int DWELL_W  = 24,
    parameter int GOOD_W   = 8,
    parameter int SLIP_W   = 8,
    parameter int ACQ_P_SH = 3,
    parameter int ACQ_I_SH = 2,
    parameter int TRK_P_SH = 0,
    parameter int TRK_I_SH = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_tick,
    input  logic               loc_tick,
    input  logic               slip_in,
    input  logic               invert_err,
    input  logic [WIN_W-1:0]   win_len,
    input  logic [DWELL_W-1:0] dwell_len,
    input  logic [CNT_W-1:0]   lock_thr,
    input  logic [CNT_W-1:0]   unlock_thr,
    input  logic [GOOD_W-1:0]  lock_n,
    output logic [DAC_W-1:0]   dac_code,
    output logic               dac_valid,
    output logic [1:0]         mode,
    output logic               locked,
    output logic [SLIP_W-1:0]  slip_count
);
    logic                    win_done;
    logic signed [CNT_W+1:0] err;
    loop_mode_e              mode_s;

    vcxo_win_meter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_meter (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .loc_tick(loc_tick),
        .invert_err(invert_err), .win_len(win_len),
        .win_done(win_done), .err(err)
    );

    vcxo_loop_filter #(
        .DAC_W(DAC_W), .CNT_W(CNT_W), .DWELL_W(DWELL_W),
        .ACQ_P_SH(ACQ_P_SH), .ACQ_I_SH(ACQ_I_SH),
        .TRK_P_SH(TRK_P_SH), .TRK_I_SH(TRK_I_SH)
    ) u_filter (
        .clk(clk), .rst(rst), .win_done(win_done), .err(err), .mode(mode_s),
        .dwell_len(dwell_len), .dac_code(dac_code), .dac_valid(dac_valid)
    );

    vcxo_lock_fsm #(.CNT_W(CNT_W), .GOOD_W(GOOD_W), .SLIP_W(SLIP_W)) u_fsm (
        .clk(clk), .rst(rst), .win_done(win_done), .err(err),
        .lock_thr(lock_thr), .unlock_thr(unlock_thr), .lock_n(lock_n),
        .slip_in(slip_in), .mode(mode_s), .locked(locked), .slip_count(slip_count)
    );

    assign mode = mode_s;

endmodule

// File: tb/vcxo_loop_ctrl_test.sv
`timescale 1ns/1ps
module vcxo_loop_ctrl_test;
    localparam longint MIDV = 512;
    localparam longint MAXV = 1023;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0, loc_tick = 1'b0, slip_in = 1'b0, invert_err = 1'b0;
    logic [15:0] win_len   = 16'd64;
    logic [23:0] dwell_len = 24'd4;
    logic [9:0]  lock_thr  = 10'd1;
    logic [9:0]  unlock_thr = 10'd4;
    logic [7:0]  lock_n    = 8'd3;
    logic [9:0]  dac_code;
    logic        dac_valid;
    logic [1:0]  mode;
    logic        locked;
    logic [7:0]  slip_count;

    always #4 clk = ~clk;

    vcxo_loop_ctrl uut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .loc_tick(loc_tick),
        .slip_in(slip_in), .invert_err(invert_err), .win_len(win_len),
        .dwell_len(dwell_len), .lock_thr(lock_thr), .unlock_thr(unlock_thr),
        .lock_n(lock_n), .dac_code(dac_code), .dac_valid(dac_valid),
        .mode(mode), .locked(locked), .slip_count(slip_count)
    );

    int n_checks = 0;
    int n_err    = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // tick generators
    int ref_per = 4, loc_per = 4, rph = 0, lph = 0;
    always @(negedge clk) begin
        rph = (rph + 1 >= ref_per) ? 0 : rph + 1;
        lph = (lph + 1 >= loc_per) ? 0 : lph + 1;
        ref_tick = (rph == 0);
        loc_tick = (lph == 0);
    end

    // behavioural reference model
    int     m_wcnt = 0, m_rc = 0, m_lc = 0, m_mode = 0, m_good = 0, m_dwell = 0, m_slips = 0;
    bit     m_done = 0, m_valid = 0, m_locked = 0, m_started = 0;
    longint m_err = 0, m_integ = 0, m_dac = MIDV, m_hacc = 0;

    function automatic longint clampb(input longint v, input longint lo, input longint hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    always @(posedge clk) begin
        longint e, p, ig, hs, ae, d;
        int     om;
        bit     quiet, loud;
        if (rst) begin
            m_wcnt = 0; m_rc = 0; m_lc = 0; m_mode = 0; m_good = 0; m_dwell = 0; m_slips = 0;
            m_done = 0; m_valid = 0; m_locked = 0; m_err = 0; m_integ = 0; m_dac = MIDV; m_hacc = 0;
        end else begin
            om = m_mode;
            if (slip_in && m_slips < 255) m_slips++;
            if (m_done) begin
                e = m_err;
                if (om == 2) begin
                    hs = m_hacc + e;
                    if (m_dwell + 1 >= int'(dwell_len)) begin
                        d = (hs > 0) ? 1 : ((hs < 0) ? -1 : 0);
                        m_dac = clampb(m_dac + d, 0, MAXV);
                        m_integ = m_dac - MIDV;
                        m_hacc = 0; m_dwell = 0; m_valid = 1;
                    end else begin
                        m_hacc = hs; m_dwell++; m_valid = 0;
                    end
                end else begin
                    p  = (om == 0) ? e * 8 : e;
                    ig = (om == 0) ? e * 4 : e;
                    m_integ = clampb(m_integ + ig, -MIDV, MIDV - 1);
                    m_dac = clampb(MIDV + m_integ + p, 0, MAXV);
                    m_valid = 1; m_hacc = 0; m_dwell = 0;
                end
                ae = (e < 0) ? -e : e;
                quiet = (ae <= longint'(lock_thr));
                loud  = (ae >  longint'(unlock_thr));
                if (om == 0) begin
                    if (quiet) begin
                        m_good++;
                        if (m_good >= int'(lock_n)) begin m_mode = 1; m_good = 0; end
                    end else m_good = 0;
                end else if (om == 1) begin
                    if (loud) begin m_mode = 0; m_good = 0; end
                    else if (quiet) begin
                        m_good++;
                        if (m_good >= int'(lock_n)) begin m_mode = 2; m_good = 0; end
                    end else m_good = 0;
                end else begin
                    if (loud) begin m_mode = 0; m_good = 0; end
                    else if (slip_in) begin m_mode = 1; m_good = 0; end
                end
            end else begin
                m_valid = 0;
                if (om != 2) begin m_hacc = 0; m_dwell = 0; end
                if (om == 2 && slip_in) begin m_mode = 1; m_good = 0; end
            end
            m_locked = (m_mode != 0);
            if (m_wcnt >= int'(win_len) - 1) begin
                m_done = 1;
                m_err = longint'(m_rc + int'(ref_tick)) - longint'(m_lc + int'(loc_tick));
                if (invert_err) m_err = -m_err;
                m_wcnt = 0; m_rc = 0; m_lc = 0;
            end else begin
                m_done = 0;
                m_wcnt++;
                m_rc += int'(ref_tick);
                m_lc += int'(loc_tick);
            end
        end
        m_started = 1;
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (m_started && !rst) begin
            chk(longint'(dac_code) == m_dac, "R3 model dac_code", longint'(dac_code), m_dac);
            chk(dac_valid == m_valid, "R3 model dac_valid", longint'(dac_valid), longint'(m_valid));
            chk(longint'(mode) == longint'(m_mode), "R5 model mode", longint'(mode), longint'(m_mode));
            chk(locked == m_locked, "R8 model locked", longint'(locked), longint'(m_locked));
            chk(longint'(slip_count) == longint'(m_slips), "R9 model slip_count",
                longint'(slip_count), longint'(m_slips));
        end
    end

    task automatic wait_win(input int n);
        repeat (n * 64) @(negedge clk);
    endtask

    task automatic pulse_slip();
        @(negedge clk); slip_in = 1'b1;
        @(negedge clk); slip_in = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int pulses;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(dac_code == 10'd512, "R1 dac_code at reset", longint'(dac_code), MIDV);
        chk(mode == 2'd0, "R1 mode at reset", longint'(mode), 0);
        chk(!locked, "R1 locked at reset", longint'(locked), 0);
        chk(!dac_valid, "R1 dac_valid at reset", longint'(dac_valid), 0);
        chk(slip_count == 8'd0, "R1 slip_count at reset", longint'(slip_count), 0);
        rst = 1'b0;

        // equal rates: zero error, lock then hold
        ref_per = 4; loc_per = 4;
        wait_win(10);
        chk(locked, "R5 locked after quiet windows", longint'(locked), 1);
        chk(mode == 2'd2, "R6 hold after second quiet run", longint'(mode), 2);
        chk(dac_code == 10'd512, "R2 zero error keeps mid code", longint'(dac_code), MIDV);

        // slightly slow reference in hold: single LSB nudges downward
        ref_per = 5;
        wait_win(16);
        chk(mode == 2'd2, "R7 still hold under small error", longint'(mode), 2);
        chk(dac_code < 10'd512 && dac_code >= 10'd507, "R7 dwell nudges lower code",
            longint'(dac_code), 508);

        // slip in hold returns to track
        pulse_slip();
        chk(mode == 2'd1, "R9 slip in hold gives track", longint'(mode), 1);
        chk(slip_count == 8'd1, "R9 slip counted", longint'(slip_count), 1);

        ref_per = 4;
        wait_win(12);
        chk(mode == 2'd2, "R6 hold regained", longint'(mode), 2);

        // large positive error: unlock
        ref_per = 2;
        wait_win(2);
        chk(mode == 2'd0, "R8 unlock to acquire", longint'(mode), 0);
        chk(!locked, "R8 locked cleared", longint'(locked), 0);

        // larger error: saturate high, one strobe per window
        loc_per = 8;
        wait_win(30);
        chk(dac_code == 10'd1023, "R4 code saturates high", longint'(dac_code), MAXV);
        chk(mode == 2'd0, "R5 no lock under large error", longint'(mode), 0);
        pulses = 0;
        for (int k = 0; k < 640; k++) begin
            @(negedge clk);
            if (dac_valid) pulses++;
        end
        chk(pulses == 10, "R3 one strobe per window", longint'(pulses), 10);

        // inverted error drives code to zero
        invert_err = 1'b1;
        wait_win(30);
        chk(dac_code == 10'd0, "R2 R4 inverted error saturates low", longint'(dac_code), 0);

        // slip in acquire: counted, mode unchanged
        pulse_slip();
        chk(mode == 2'd0, "R9 slip in acquire keeps mode", longint'(mode), 0);
        chk(slip_count == 8'd2, "R9 second slip counted", longint'(slip_count), 2);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule